// File: doc/BRIEF.md
# Daisy-Chained Bus Arbiter

This block decides which of several devices owns a shared bus. Every device drives its own request bit. The bits merge into one shared request line by an OR, which models a wired-OR line. When the central controller sees that line high, it raises a single acknowledge into the first cell of a chain. Each cell adds one register stage. A cell that is not requesting hands the acknowledge on to its neighbour. A cell that is requesting keeps it and owns the bus. Priority comes only from position: device 1 is nearest the controller and wins over every device behind it.

The owner ends its tenure by pulsing its done bit. Only the owner's done bit reaches the shared release line. The controller then drops the acknowledge. It waits long enough for the withdrawal to clear the whole chain, returns to idle, and offers the bus again only if the request line is high. The block has no data path. Requests, done pulses and grants are plain level control pins. No valid/ready handshake applies.

Top module: `daisy_arb_top`

## Requirements
- R1: During and right after reset, all grant bits, the acknowledge and the release line are low.
- R2: The shared request line equals the OR of all device request bits in the same cycle. The acknowledge rises only in the cycle after an idle cycle in which that line was high.
- R3: Bit i of each device vector belongs to device i+1. Device k first sees a raised acknowledge k cycles after the acknowledge rises. If it requests in that cycle, its grant bit is high from that cycle on.
- R4: When several devices request, the one with the lowest device number that is requesting as the acknowledge reaches it gets the grant. Devices behind it never see the acknowledge.
- R5: At most one grant bit is high in any cycle.
- R6: The release line is high only when a device whose grant bit is high pulses its done bit. A done pulse from a device without a grant has no effect on grants or on the acknowledge.
- R7: The acknowledge falls in the cycle after release is seen. The owner's grant falls k cycles after the acknowledge falls. The controller then holds the acknowledge low for N+1 more cycles before it can re-offer the bus.
- R8: If the acknowledge passes the last device without any device taking it, the controller withdraws it in the next cycle.
- R9: A device that drops its request before the acknowledge reaches it passes the acknowledge on, and a later requester may take it.
- R10: While device 1 keeps requesting again after each release, device N never receives a grant, even though it requests the whole time.
- R11: An owner keeps its grant after dropping its request, until it releases the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | N_DEV | Request bit per device (bit 0 = device 1, highest priority) |
| dev_done | input | N_DEV | Done pulse per device; counts only from the owner |
| dev_grant | output | N_DEV | Ownership bit per device |
| bus_ack | output | 1 | Acknowledge driven into the head of the chain |
| bus_req | output | 1 | Shared OR-combined request line |
| bus_rel | output | 1 | Shared release line |

## Verification
The bench aims at the corner cases most likely to break ownership. These are a non-owner done pulse, which a careless design would treat as a release and use to steal the bus. A request dropped just before the acknowledge arrives, which a bad cell would keep as a grant or fail to pass on. An acknowledge that runs off the end of the chain, which would hang the controller in the offer state. A new offer issued too early, before the old grant has drained from a distant cell, which would leave two owners at once. The starvation pattern shows that device N stays locked out while device 1 keeps requesting. It also shows that a wrong priority order would hand device N the bus.

// File: rtl/daisy_arb_pkg.sv
package daisy_arb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE   = 2'd0,
    ARB_OFFER  = 2'd1,
    ARB_RETIRE = 2'd2
  } arb_state_e;
endpackage

// File: rtl/daisy_arb_ctrl.sv
module daisy_arb_ctrl #(
  parameter int N_DEV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_line,
  input  logic rel_line,
  input  logic tail_ack,
  output logic ack_out
);
  import daisy_arb_pkg::*;
  localparam int CW = $clog2(N_DEV + 1);
  localparam logic [CW-1:0] DRAIN_LAST = CW'(N_DEV);

  arb_state_e     state_q;
  logic [CW-1:0]  drain_q;
  logic           ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      drain_q <= '0;
      ack_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ARB_IDLE: begin
          if (req_line) begin
            ack_q   <= 1'b1;
            state_q <= ARB_OFFER;
          end
        end
        ARB_OFFER: begin
          if (rel_line || tail_ack) begin
            ack_q   <= 1'b0;
            drain_q <= '0;
            state_q <= ARB_RETIRE;
          end
        end
        ARB_RETIRE: begin
          if (drain_q == DRAIN_LAST) state_q <= ARB_IDLE;
          else                       drain_q <= drain_q + 1'b1;
        end
        default: state_q <= ARB_IDLE;
      endcase
    end
  end

  assign ack_out = ack_q;

  // R2
  ack_rise_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> $past(req_line));
  // R7
  ack_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_q) |-> ($past(rel_line) || $past(tail_ack)));
  // R7
  retire_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ARB_RETIRE) |=> !ack_q);
endmodule

// File: rtl/daisy_grant_cell.sv
module daisy_grant_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_in,
  input  logic req,
  input  logic done,
  output logic ack_out,
  output logic grant,
  output logic rel_out
);
  logic seen_q, own_q, pass_q, fresh;

  assign fresh   = seen_q & ~own_q & ~pass_q;
  assign grant   = seen_q & (own_q | (fresh & req));
  assign ack_out = seen_q & (pass_q | (fresh & ~req));
  assign rel_out = done & grant;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      own_q  <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      seen_q <= ack_in;
      own_q  <= grant;
      pass_q <= ack_out;
    end
  end

  // R4
  take_or_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && ack_out));
  // R3
  one_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_out) |-> $past(ack_in));
  // R11
  hold_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && ack_in) |=> grant);
endmodule

// File: rtl/daisy_arb_top.sv
module daisy_arb_top #(
  parameter int N_DEV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DEV-1:0] dev_req,
  input  logic [N_DEV-1:0] dev_done,
  output logic [N_DEV-1:0] dev_grant,
  output logic             bus_ack,
  output logic             bus_req,
  output logic             bus_rel
);
  logic [N_DEV:0]   chain;
  logic [N_DEV-1:0] rel_vec;

  assign bus_req = |dev_req;
  assign bus_rel = |rel_vec;

  daisy_arb_ctrl #(.N_DEV(N_DEV)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_line(bus_req), .rel_line(bus_rel),
    .tail_ack(chain[N_DEV]), .ack_out(bus_ack)
  );

  assign chain[0] = bus_ack;

  for (genvar i = 0; i < N_DEV; i++) begin : g_cell
    daisy_grant_cell u_cell (
      .clk(clk), .rst_n(rst_n), .ack_in(chain[i]), .req(dev_req[i]),
      .done(dev_done[i]), .ack_out(chain[i+1]), .grant(dev_grant[i]),
      .rel_out(rel_vec[i])
    );
  end

  // R5
  single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_grant));
  // R6
  rel_from_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rel |-> (|(dev_grant & dev_done)));
endmodule

// File: tb/daisy_arb_top_test.sv
module daisy_arb_top_test;
  localparam int N = 4;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] dev_req = '0, dev_done = '0;
  logic [N-1:0] dev_grant;
  logic bus_ack, bus_req, bus_rel;

  int checks = 0, errors = 0;
  string tag = "R3";
  int cyc = 0;
  int m_phase = 0, m_rc = 0, m_owner = 0;
  int t_rise = -1, t_fall = -1;
  bit m_ack = 0, done_flag = 0;
  int last_grants = 0, first_grants = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  daisy_arb_top #(.N_DEV(N)) uut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic bit sees(int k, int c);
    return t_rise >= 0 && c >= t_rise + k && (t_fall < t_rise || c < t_fall + k);
  endfunction

  task automatic step(input logic [N-1:0] r, input logic [N-1:0] d);
    logic [N-1:0] exp_g;
    bit tail, rel;
    int front;
    @(negedge clk);
    dev_req = r; dev_done = d;
    #1;
    exp_g = '0; tail = 0;
    front = cyc - t_rise;
    if (m_phase == 1 && m_owner == 0 && front >= 1 && front <= N) begin
      if (r[front-1]) m_owner = front;
      else if (front == N) tail = 1;
    end
    if (m_owner > 0 && sees(m_owner, cyc)) exp_g[m_owner-1] = 1'b1;
    rel = |(exp_g & d);
    chk(dev_grant == exp_g, tag, "grant", dev_grant, exp_g);
    chk(bus_ack == m_ack, "R7", "ack", bus_ack, m_ack);
    chk(bus_req == (|r), "R2", "req line", bus_req, |r);
    chk(bus_rel == rel, "R6", "release", bus_rel, rel);
    chk($countones(dev_grant) <= 1, "R5", "owners", $countones(dev_grant), 1);
    if (dev_grant[N-1]) last_grants++;
    if (dev_grant[0]) first_grants++;
    // model of the coming edge
    case (m_phase)
      0: if (|r) begin m_ack = 1; m_phase = 1; t_rise = cyc + 1; m_owner = 0; end
      1: if (rel || tail) begin m_ack = 0; m_phase = 2; m_rc = 0; t_fall = cyc + 1; end
      default: if (m_rc == N) m_phase = 0; else m_rc++;
    endcase
    cyc++;
  endtask

  task automatic run(input logic [N-1:0] r, input logic [N-1:0] d, input int n);
    for (int i = 0; i < n; i++) step(r, d);
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(dev_grant == '0, "R1", "grant in reset", dev_grant, 0);
    chk(bus_ack == 1'b0, "R1", "ack in reset", bus_ack, 0);
    chk(bus_rel == 1'b0, "R1", "rel in reset", bus_rel, 0);
    rst_n = 1'b1;
    run('0, '0, 3);
    // R3 / R6 / R11: devices 2 and 4 ask; device 2 owns, device 4 done ignored
    tag = "R3";
    run(4'b1010, '0, 5);
    tag = "R6";
    run(4'b1000, 4'b1000, 3);
    tag = "R11";
    run(4'b1000, '0, 2);
    run(4'b1000, 4'b0010, 1);
    run('0, '0, 12);
    // R4: everyone asks at once
    tag = "R4";
    run(4'b1111, '0, 4);
    run(4'b1111, 4'b0001, 1);
    run('0, '0, 10);
    // R9: device 3 drops before the acknowledge arrives, device 4 takes it
    tag = "R9";
    run(4'b0100, '0, 2);
    run(4'b1000, '0, 8);
    run(4'b1000, 4'b1000, 1);
    run('0, '0, 12);
    // R8: request vanishes, acknowledge runs off the end
    tag = "R8";
    run(4'b0010, '0, 1);
    run('0, '0, 14);
    chk(bus_ack == 1'b0 && dev_grant == '0, "R8", "ack withdrawn", bus_ack, 0);
    // R10: device 1 re-requests after each release, device 4 starves
    tag = "R10";
    last_grants = 0; first_grants = 0;
    for (int k = 0; k < 6; k++) begin
      run(4'b1001, '0, 4);
      run(4'b1001, 4'b0001, 1);
      run(4'b1001, '0, 6);
    end
    chk(last_grants == 0, "R10", "device N grants", last_grants, 0);
    chk(first_grants > 0, "R10", "device 1 served", first_grants, 1);
    // R3: once device 1 stops, device N finally gets through
    tag = "R3";
    run(4'b1000, '0, 12);
    chk(dev_grant == 4'b1000, "R3", "device N owns", dev_grant, 4'b1000);
    finish_run();
  end
endmodule